// File: doc/BRIEF.md
# Polarity-Configurable General-Purpose I/O Port

This block is a sixteen-pin general-purpose I/O port with a small word-addressed register interface. Every pin is set up by four per-pin registers: an output data word, a direction word (input or output), a sense word (push-pull or open-drain output) and a polarity word. Inside the block, data is always active-high. The polarity bit decides whether the pin uses the same convention or the opposite one. It applies in both directions: it inverts a sampled input before software sees it, and it inverts an output before the pad sees it. For open-drain pins it also decides which data value pulls the line low and which value lets it float.

For each pin the block drives an output value and an output-enable toward a tristate pad. It also samples the pad level through a two-flop synchronizer. Software accesses the registers through one address bus with a write strobe. Read data comes back combinationally from the selected register.

Top module: `gpio_pol_port`

## Requirements
- R1: After reset, the data, direction, sense and polarity words all read zero, and every padOe and padOut bit is 0. All pins therefore start as inputs with polarity inversion enabled.
- R2: Bits 31:16 of every read are zero. The write bits 31:16 have no effect on any register.
- R3: For an input pin (direction bit 0), bit i of a read at byte offset 0x04 returns the pin level when polarity bit i is 1, and its complement when it is 0. A pin change made between clock edges is not visible after the first rising edge but is visible after the second.
- R4: For a push-pull output (direction 1, sense 0), padOe is 1. padOut equals the data bit when polarity is 1 and its complement when polarity is 0.
- R5: For an open-drain output (direction 1, sense 1), padOut is 0. With polarity 1, data 0 sets padOe to 1 (drive low) and data 1 sets padOe to 0 (released). With polarity 0 the roles are swapped.
- R6: An input pin never drives: padOe and padOut are 0 whatever its sense, data or polarity bits hold.
- R7: Registers sit at byte offsets 0x04 (data), 0x08 (direction, 1 = output), 0x0C (sense, 1 = open-drain) and 0x10 (polarity, 1 = pass-through). A write with wrEn high is captured at that rising edge. Before that edge a read returns the old value, and after it the new value.
- R8: For an output pin, bit i of a read at 0x04 returns the written data bit, whatever the pin level.
- R9: Writes to any other offset change no register. Reads from those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and synchronizer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | 8 | Byte offset of the register being accessed |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the addressed register |
| pinsIn | input | 16 | Levels sampled from the pads |
| padOut | output | 16 | Value driven toward each pad |
| padOe | output | 16 | Output-enable for each pad |

## Verification
The bench builds the block with its defaults: sixteen pins, a 32-bit register word, an 8-bit byte address and a two-stage synchronizer. The 8-bit address leaves many unmapped offsets, such as 0x00, 0x14 and 0x1C, so the bench can write to them and show that nothing changes. With two synchronizer stages, the bench can check latency exactly, one edge and then two edges after a pin change. With sixteen pins, a random word mixes every direction, sense and polarity combination in a single step.

// File: rtl/gpio_pol_pkg.sv
package gpio_pol_pkg;

  // Byte offsets of the port registers
  localparam int OFF_DATA  = 32'h04;
  localparam int OFF_DIR   = 32'h08;
  localparam int OFF_SENSE = 32'h0C;
  localparam int OFF_POL   = 32'h10;

  // Write strobes from the decoder to the register datapath
  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrSense;
    logic wrPol;
  } regStrobe_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_SENSE,
    SEL_POL
  } rdSel_e;

endpackage

// File: rtl/gpio_pol_sync.sv
module gpio_pol_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= '0;
          else       stage[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage[STAGES-1];

endmodule

// File: rtl/gpio_pol_ctrl.sv
module gpio_pol_ctrl
  import gpio_pol_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strb,
  output rdSel_e            rdSel
);

  always_comb begin
    strb  = '0;
    rdSel = SEL_NONE;
    case (32'(addr))
      OFF_DATA: begin
        rdSel       = SEL_DATA;
        strb.wrData = wrEn;
      end
      OFF_DIR: begin
        rdSel      = SEL_DIR;
        strb.wrDir = wrEn;
      end
      OFF_SENSE: begin
        rdSel        = SEL_SENSE;
        strb.wrSense = wrEn;
      end
      OFF_POL: begin
        rdSel      = SEL_POL;
        strb.wrPol = wrEn;
      end
      default: begin
        rdSel = SEL_NONE;
      end
    endcase
  end

endmodule

// File: rtl/gpio_pol_dp.sv
module gpio_pol_dp
  import gpio_pol_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int REG_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strb,
  input  rdSel_e              rdSel,
  input  logic [REG_W-1:0]    wrData,
  input  logic [NUM_PINS-1:0] pinsIn,
  output logic [REG_W-1:0]    rdData,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] dirQ,
  output logic [NUM_PINS-1:0] senseQ,
  output logic [NUM_PINS-1:0] polQ
);

  logic [NUM_PINS-1:0] dataQ;
  logic [NUM_PINS-1:0] wrLow;
  logic [NUM_PINS-1:0] pinsSync;
  logic [NUM_PINS-1:0] pinLevel;   // input after polarity correction
  logic [NUM_PINS-1:0] drvLevel;   // output after polarity correction
  logic [NUM_PINS-1:0] dataView;

  assign wrLow = wrData[NUM_PINS-1:0];

  // Upper write bits are reserved and dropped
  generate
    if (REG_W > NUM_PINS) begin : g_resv
      logic resvUnused;
      assign resvUnused = ^wrData[REG_W-1:NUM_PINS];
    end
  endgenerate

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      dirQ   <= '0;
      senseQ <= '0;
      polQ   <= '0;
    end else begin
      if (strb.wrData)  dataQ  <= wrLow;
      if (strb.wrDir)   dirQ   <= wrLow;
      if (strb.wrSense) senseQ <= wrLow;
      if (strb.wrPol)   polQ   <= wrLow;
    end
  end

  gpio_pol_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .async_i (pinsIn),
    .sync_o  (pinsSync)
  );

  // Polarity 1 passes through, polarity 0 inverts
  assign pinLevel = pinsSync ^ ~polQ;
  assign drvLevel = dataQ ^ ~polQ;

  // Per-pin pad drive
  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
      logic oeBit;
      logic outBit;
      always_comb begin
        case ({dirQ[i], senseQ[i]})
          2'b10: begin          // push-pull output
            oeBit  = 1'b1;
            outBit = drvLevel[i];
          end
          2'b11: begin          // open-drain output: only pulls low
            oeBit  = ~drvLevel[i];
            outBit = 1'b0;
          end
          default: begin        // input pin
            oeBit  = 1'b0;
            outBit = 1'b0;
          end
        endcase
      end
      assign padOe[i]  = oeBit;
      assign padOut[i] = outBit;
      assign dataView[i] = dirQ[i] ? dataQ[i] : pinLevel[i];
    end
  endgenerate

  // Read mux
  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_DATA:  rdData[NUM_PINS-1:0] = dataView;
      SEL_DIR:   rdData[NUM_PINS-1:0] = dirQ;
      SEL_SENSE: rdData[NUM_PINS-1:0] = senseQ;
      SEL_POL:   rdData[NUM_PINS-1:0] = polQ;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_pol_port.sv
module gpio_pol_port
  import gpio_pol_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int REG_W       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wrData,
  output logic [REG_W-1:0]    rdData,
  input  logic [NUM_PINS-1:0] pinsIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe
);

  regStrobe_t          strb;
  rdSel_e              rdSel;
  logic [NUM_PINS-1:0] dirQ;
  logic [NUM_PINS-1:0] senseQ;
  logic [NUM_PINS-1:0] polQ;

  gpio_pol_ctrl #(
    .ADDR_W (ADDR_W)
  ) ctrl_i (
    .wrEn  (wrEn),
    .addr  (addr),
    .strb  (strb),
    .rdSel (rdSel)
  );

  gpio_pol_dp #(
    .NUM_PINS    (NUM_PINS),
    .REG_W       (REG_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdSel  (rdSel),
    .wrData (wrData),
    .pinsIn (pinsIn),
    .rdData (rdData),
    .padOut (padOut),
    .padOe  (padOe),
    .dirQ   (dirQ),
    .senseQ (senseQ),
    .polQ   (polQ)
  );

endmodule

// File: rtl/gpio_pol_chk.sv
module gpio_pol_chk #(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [NUM_PINS-1:0] wrLow,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] dirQ,
  input logic [NUM_PINS-1:0] senseQ,
  input logic [NUM_PINS-1:0] polQ
);

  logic polWrite;
  logic unmappedWrite;

  assign polWrite = wrEn && (32'(addr) == 32'h10);
  assign unmappedWrite = wrEn && (32'(addr) != 32'h04) && (32'(addr) != 32'h08) &&
                         (32'(addr) != 32'h0C) && (32'(addr) != 32'h10);

  // R6: an input pin never enables its pad
  a_r6_input_released: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & ~dirQ) == '0);

  // R5: an open-drain pin never drives high
  a_r5_od_pulls_low_only: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padOut & senseQ & dirQ) == '0);

  // R4: a push-pull output always has its enable on
  a_r4_push_pull_enabled: assert property (@(posedge clk) disable iff (!rstN)
    ((dirQ & ~senseQ) & ~padOe) == '0);

  // R7: a polarity write lands at the edge of the strobe
  a_r7_pol_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    polWrite |=> polQ == $past(wrLow));

  // R9: writes to unmapped offsets leave configuration alone
  a_r9_unmapped_ignored: assert property (@(posedge clk) disable iff (!rstN)
    unmappedWrite |=> ($stable(dirQ) && $stable(senseQ) && $stable(polQ)));

endmodule

bind gpio_pol_port gpio_pol_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrLow  (wrData[NUM_PINS-1:0]),
  .padOut (padOut),
  .padOe  (padOe),
  .dirQ   (dirQ),
  .senseQ (senseQ),
  .polQ   (polQ)
);

// File: tb/gpio_pol_port_tb.sv
`timescale 1ns/1ps
module gpio_pol_port_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [15:0] pinsIn = '0;
  logic [15:0] padOut;
  logic [15:0] padOe;

  int nTests = 0;
  int nFails = 0;

  // bench model of the registers
  logic [15:0] mData = '0, mDir = '0, mSense = '0, mPol = '0;

  always #4 clk = ~clk;   // 125 MHz

  gpio_pol_port dut_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .pinsIn (pinsIn),
    .padOut (padOut),
    .padOe  (padOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expDrv();
    return mData ^ ~mPol;
  endfunction

  function automatic logic [15:0] expOe();
    logic [15:0] d = expDrv();
    return (mDir & ~mSense) | (mDir & mSense & ~d);
  endfunction

  function automatic logic [15:0] expOut();
    return mDir & ~mSense & expDrv();
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h04:   return {16'h0, (mDir & mData) | (~mDir & (pinsIn ^ ~mPol))};
      8'h08:   return {16'h0, mDir};
      8'h0C:   return {16'h0, mSense};
      8'h10:   return {16'h0, mPol};
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      8'h04: mData  = d[15:0];
      8'h08: mDir   = d[15:0];
      8'h0C: mSense = d[15:0];
      8'h10: mPol   = d[15:0];
      default: ;
    endcase
  endtask

  task automatic rdChk(input string req, input logic [7:0] a);
    @(negedge clk);
    wrEn = 1'b0; addr = a;
    #1;
    chk(req, rdData, expRead(a));
  endtask

  task automatic padChk(input string req);
    @(negedge clk);
    #1;
    chk({req, " oe"}, {16'h0, padOe}, {16'h0, expOe()});
    chk({req, " out"}, {16'h0, padOut}, {16'h0, expOut()});
  endtask

  task automatic setPins(input logic [15:0] p);
    @(negedge clk);
    pinsIn = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic allRegs(input string req);
    rdChk(req, 8'h04);
    rdChk(req, 8'h08);
    rdChk(req, 8'h0C);
    rdChk(req, 8'h10);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    nTests++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin : stim
    logic [7:0] addrs [7];
    addrs = '{8'h04, 8'h08, 8'h0C, 8'h10, 8'h00, 8'h14, 8'h1C};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    padChk("R1");
    allRegs("R1");

    // R3 input polarity and sync latency
    setPins(16'h00FF);
    rdChk("R3 inverted input", 8'h04);
    @(negedge clk);
    pinsIn = 16'hA5A5; addr = 8'h04; #1;
    chk("R3 no change before edge", rdData, 32'h0000FF00);
    @(negedge clk); #1;
    chk("R3 one edge still old", rdData, 32'h0000FF00);
    @(negedge clk); #1;
    chk("R3 two edges new", rdData, 32'h00005A5A);
    wr(8'h10, 32'h0000FFFF);
    rdChk("R3 pass-through input", 8'h04);

    // R7 write lands on the strobed edge
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h10; wrData = 32'h00001234; #1;
    chk("R7 old before edge", rdData, 32'h0000FFFF);
    @(negedge clk); #1;
    wrEn = 1'b0;
    chk("R7 new after edge", rdData, 32'h00001234);
    mPol = 16'h1234;

    // R6 input pins never drive
    wr(8'h0C, 32'h0000FFFF);
    wr(8'h04, 32'h00003C3C);
    padChk("R6");

    // R4 push-pull both polarities, R8 readback
    wr(8'h0C, 32'h0);
    wr(8'h08, 32'h0000FFFF);
    wr(8'h04, 32'h00000F0F);
    wr(8'h10, 32'h0);
    padChk("R4 inverted");
    chk("R4 inverted value", {16'h0, padOut}, 32'h0000F0F0);
    wr(8'h10, 32'h0000FFFF);
    padChk("R4 buffered");
    setPins(16'hFFFF);
    rdChk("R8 output data readback", 8'h04);

    // R5 open-drain both polarities
    wr(8'h0C, 32'h0000FFFF);
    padChk("R5 pol1");
    chk("R5 pol1 oe", {16'h0, padOe}, 32'h0000F0F0);
    wr(8'h10, 32'h0);
    padChk("R5 pol0");
    chk("R5 pol0 oe", {16'h0, padOe}, 32'h00000F0F);

    // R2 reserved bits
    wr(8'h10, 32'hFFFF0000);
    rdChk("R2 reserved write ignored", 8'h10);
    wr(8'h08, 32'hABCD1234);
    rdChk("R2 upper read zero", 8'h08);

    // R9 unmapped offsets
    wr(8'h00, 32'hFFFFFFFF);
    wr(8'h14, 32'h0000FFFF);
    wr(8'h1C, 32'h00005555);
    allRegs("R9 unmapped write");
    rdChk("R9 unmapped read", 8'h14);
    padChk("R9 pads");

    // Random mix
    for (int it = 0; it < 300; it++) begin
      setPins(16'($urandom));
      wr(addrs[$urandom_range(0, 6)], $urandom);
      padChk("R4/R5/R6 random");
      allRegs("R3/R7/R8 random");
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule